// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit multiplication and division over many cycles and keeps its results in two result registers, HI and LO. A pipeline hands it an operation and two operands through a valid/ready request port. The unit accepts the request, works on it one bit per cycle for 32 cycles, and then writes both result registers in the same clock edge. A multiply puts the full 64-bit product across the two registers, low word in LO and high word in HI. A divide puts the quotient in LO and the remainder in HI.

Both registers can also be loaded directly from a shared data input, which gives the move-to-HI and move-to-LO functions. Their current contents are always visible on two outputs, which gives move-from-HI and move-from-LO. The unit has no interlock of its own. A pipeline that reads a result must stall while `busy` is high. The unit raises no exceptions, and a divide by zero simply leaves HI and LO as they were.

The request port follows valid/ready rules. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole computation. The requester holds its request stable, or withdraws it, while ready is low. A request offered while ready is low has no effect. There is no back-pressure on the result side: results appear in HI/LO on the edge where `busy` falls.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO read 0, `busy` is 0 and `req_ready` is 1.
- R2: A request is taken only on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is the inverse of `busy`. A request presented while `busy` is high starts nothing and leaves HI and LO unchanged.
- R3: After an accepting edge, `busy` is high for exactly 32 clock cycles. HI and LO hold their values during that time, and both take their new values on the edge where `busy` falls.
- R4: `req_op` = 0 is a signed multiply. The two's-complement 64-bit product of both operands goes with bits 31:0 to LO and bits 63:32 to HI.
- R5: `req_op` = 1 is an unsigned multiply. The 64-bit product of the operands, both read as unsigned, is split the same way as in R4.
- R6: `req_op` = 3 is an unsigned divide of `req_a` by `req_b`. The quotient goes to LO and the remainder goes to HI.
- R7: `req_op` = 2 is a signed divide. The quotient is truncated toward zero and the remainder carries the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R8: A divide (op 2 or 3) with `req_b` = 0 still keeps `busy` high for 32 cycles, but leaves both HI and LO unchanged.
- R9: While `busy` is low, `wr_hi` loads HI from `wr_data` and `wr_lo` loads LO from `wr_data` on the next edge. While `busy` is high, both write strobes are ignored.
- R10: Asserting `wr_hi` and `wr_lo` together while idle loads both registers with `wr_data` on the same edge. Each strobe alone changes only its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Unit can take a request (idle) |
| req_op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| req_a | input | 32 | Multiplicand / dividend |
| req_b | input | 32 | Multiplier / divisor |
| busy | output | 1 | Computation in progress; external stall request |
| wr_hi | input | 1 | Direct load of HI |
| wr_lo | input | 1 | Direct load of LO |
| wr_data | input | 32 | Data for direct loads |
| hi_out | output | 32 | Current HI contents |
| lo_out | output | 32 | Current LO contents |

## Verification
The assertions assume that the reset is applied before any request, and that the request and write inputs change only away from the rising edge. They also assume that `req_b` is sampled at the accepting edge, which is how the checker records a divisor of zero. The stimulus drives every input on the falling edge. It holds each request for exactly one accepting edge. It places write strobes and extra requests only inside busy windows, where they must have no effect, or in idle cycles apart from any accept. This keeps the outcome of a combined write-and-accept edge out of the expected values.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    MD_MUL_S = 2'd0,
    MD_MUL_U = 2'd1,
    MD_DIV_S = 2'd2,
    MD_DIV_U = 2'd3
  } md_op_e;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic step,
  output logic last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  logic [CW-1:0] cnt;

  assign step = busy;
  assign last = busy && (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_mag,
  input  logic [W-1:0]   b_mag,
  output logic [2*W-1:0] prod_nxt
);
  logic [W-1:0]   mcand;
  logic [2*W-1:0] acc;
  logic [W:0]     upper_sum;

  always_comb begin
    upper_sum = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mcand} : '0);
    prod_nxt  = {upper_sum, acc[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (load) begin
      mcand <= a_mag;
      acc   <= {{W{1'b0}}, b_mag};
    end else if (step) begin
      acc <= prod_nxt;
    end
  end
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] n_mag,
  input  logic [W-1:0] d_mag,
  output logic [W-1:0] quo_nxt,
  output logic [W-1:0] rem_nxt
);
  logic [W-1:0] dvsr;
  logic [W-1:0] quo;
  logic [W-1:0] rem;
  logic [W:0]   shifted;
  logic [W:0]   diff;
  logic         fits;

  always_comb begin
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, dvsr};
    fits    = (shifted >= {1'b0, dvsr});
    quo_nxt = {quo[W-2:0], fits};
    rem_nxt = fits ? diff[W-1:0] : shifted[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dvsr <= d_mag;
      quo  <= n_mag;
      rem  <= '0;
    end else if (step) begin
      quo <= quo_nxt;
      rem <= rem_nxt;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out
);
  import mdu_pkg::*;

  md_op_e         op_in;
  logic           start, step, last;
  logic           signed_op, a_neg, b_neg;
  logic [W-1:0]   a_mag, b_mag;
  logic           r_is_div, r_neg_q, r_neg_r, r_dz;
  logic [2*W-1:0] prod_nxt, prod_fix;
  logic [W-1:0]   quo_nxt, rem_nxt, quo_fix, rem_fix;
  logic [W-1:0]   hi_q, lo_q;

  assign op_in     = md_op_e'(req_op);
  assign req_ready = !busy;
  assign start     = req_valid && !busy;

  assign signed_op = (op_in == MD_MUL_S) || (op_in == MD_DIV_S);
  assign a_neg     = signed_op && req_a[W-1];
  assign b_neg     = signed_op && req_b[W-1];
  assign a_mag     = a_neg ? (~req_a + 1'b1) : req_a;
  assign b_mag     = b_neg ? (~req_b + 1'b1) : req_b;

  mdu_seq #(.W(W)) seq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .step  (step),
    .last  (last)
  );

  mdu_mul_core #(.W(W)) mul_i (
    .clk      (clk),
    .load     (start),
    .step     (step),
    .a_mag    (a_mag),
    .b_mag    (b_mag),
    .prod_nxt (prod_nxt)
  );

  mdu_div_core #(.W(W)) div_i (
    .clk     (clk),
    .load    (start),
    .step    (step),
    .n_mag   (a_mag),
    .d_mag   (b_mag),
    .quo_nxt (quo_nxt),
    .rem_nxt (rem_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_is_div <= 1'b0;
      r_neg_q  <= 1'b0;
      r_neg_r  <= 1'b0;
      r_dz     <= 1'b0;
    end else if (start) begin
      r_is_div <= (op_in == MD_DIV_S) || (op_in == MD_DIV_U);
      r_neg_q  <= a_neg ^ b_neg;
      r_neg_r  <= a_neg;
      r_dz     <= (req_b == '0);
    end
  end

  always_comb begin
    prod_fix = r_neg_q ? (~prod_nxt + 1'b1) : prod_nxt;
    quo_fix  = r_neg_q ? (~quo_nxt + 1'b1) : quo_nxt;
    rem_fix  = r_neg_r ? (~rem_nxt + 1'b1) : rem_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (last) begin
      if (!r_is_div) begin
        hi_q <= prod_fix[2*W-1:W];
        lo_q <= prod_fix[W-1:0];
      end else if (!r_dz) begin
        hi_q <= rem_fix;
        lo_q <= quo_fix;
      end
    end else if (!busy) begin
      if (wr_hi) hi_q <= wr_data;
      if (wr_lo) lo_q <= wr_data;
    end
  end

  assign hi_out = hi_q;
  assign lo_out = lo_q;
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [1:0]   req_op,
  input logic [W-1:0] req_b,
  input logic         busy,
  input logic         wr_hi,
  input logic         wr_lo,
  input logic [W-1:0] hi_out,
  input logic [W-1:0] lo_out
);
  logic [7:0] run_cnt;
  logic       dz_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      dz_div  <= 1'b0;
    end else if (req_valid && req_ready) begin
      run_cnt <= 8'd1;
      dz_div  <= req_op[1] && (req_b == '0);
    end else if (busy) begin
      run_cnt <= run_cnt + 8'd1;
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt < 8'(W)) |=> busy);

  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt == 8'(W)) |=> !busy);

  p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt < 8'(W)) |=> ($stable(hi_out) && $stable(lo_out)));

  p_divzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt == 8'(W) && dz_div) |=> ($stable(hi_out) && $stable(lo_out)));

  p_idle_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_hi) |=> $stable(hi_out));

  p_idle_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_lo) |=> $stable(lo_out));
endmodule

bind muldiv_hilo mdu_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_b     (req_b),
  .busy      (busy),
  .wr_hi     (wr_hi),
  .wr_lo     (wr_lo),
  .hi_out    (hi_out),
  .lo_out    (lo_out)
);

// File: tb/muldiv_hilo_tb_top.sv
module muldiv_hilo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_a = '0, req_b = '0;
  logic        busy;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] hi_out, lo_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  muldiv_hilo dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] hi,
                                        input logic [31:0] lo);
    longint sa, sb, q, r;
    logic [63:0] p;
    case (op)
      2'd0: begin sa = longint'($signed(a)); sb = longint'($signed(b)); p = 64'(sa * sb); return p; end
      2'd1: begin p = {32'd0, a} * {32'd0, b}; return p; end
      2'd2: begin
        if (b == 0) return {hi, lo};
        sa = longint'($signed(a)); sb = longint'($signed(b));
        q = sa / sb; r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {hi, lo};
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string tag(input logic [1:0] op, input logic [31:0] b);
    if (op[1] && b == 0) return "R8";
    case (op)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R7";
      default: return "R6";
    endcase
  endfunction

  // Issues one operation; optionally pokes writes and a second request mid-run.
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input bit poke);
    logic [63:0] exp;
    logic [31:0] h0, l0;
    h0 = hi_out; l0 = lo_out;
    exp = model(op, a, b, h0, l0);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy after accept", {63'd0, busy}, 64'd1);
    for (int i = 1; i <= 32; i++) begin
      if (poke && i == 5) begin
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h5A5A_0F0F;
        req_valid = 1'b1; req_op = 2'd1; req_a = 32'h7; req_b = 32'h9;
      end
      @(negedge clk);
      wr_hi = 1'b0; wr_lo = 1'b0; req_valid = 1'b0;
      if (i == 6 && poke) begin
        check("R2 ready low while busy", {63'd0, req_ready}, 64'd0);
        check("R9 write ignored while busy", {hi_out, lo_out}, {h0, l0});
      end
      if (i == 31) check("R3 busy held, hilo stable", {31'd0, busy, hi_out}, {31'd0, 1'b1, h0});
    end
    check("R3 busy falls after 32", {63'd0, busy}, 64'd0);
    check(tag(op, b), {hi_out, lo_out}, exp);
  endtask

  task automatic idle_write(input bit h, input bit l, input logic [31:0] d);
    logic [31:0] eh, el;
    eh = h ? d : hi_out;
    el = l ? d : lo_out;
    @(negedge clk);
    wr_hi = h; wr_lo = l; wr_data = d;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
    check((h && l) ? "R10 dual write" : "R9 single write", {hi_out, lo_out}, {eh, el});
  endtask

  initial begin
    int seed;
    logic [1:0] op;
    logic [31:0] a, b;
    seed = 32'h1357;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 reset hilo", {hi_out, lo_out}, 64'd0);
    check("R1 reset busy/ready", {62'd0, busy, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    idle_write(1, 0, 32'hCAFE_0001);
    idle_write(0, 1, 32'h0BAD_0002);
    idle_write(1, 1, 32'h1234_5678);

    run_op(2'd0, 32'hFFFF_FFFF, 32'h0000_0002, 1);   // R4 -1*2
    run_op(2'd0, 32'h8000_0000, 32'h8000_0000, 0);   // R4
    run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R5
    run_op(2'd3, 32'd100, 32'd7, 0);                 // R6
    run_op(2'd3, 32'hFFFF_FFFF, 32'd1, 0);           // R6
    run_op(2'd2, 32'hFFFF_FFF9, 32'd2, 0);           // R7 -7/2
    run_op(2'd2, 32'd7, 32'hFFFF_FFFE, 0);           // R7 7/-2
    run_op(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 0);   // R7 overflow case
    idle_write(1, 1, 32'hDEAD_BEEF);
    run_op(2'd3, 32'd55, 32'd0, 0);                  // R8
    run_op(2'd2, 32'h8000_0001, 32'd0, 1);           // R8 with pokes

    for (int n = 0; n < 60; n++) begin
      op = 2'($urandom_range(0, 3));
      a = $urandom();
      b = ($urandom_range(0, 9) == 0) ? 32'd0 : $urandom() >> $urandom_range(0, 31);
      run_op(op, a, b, ($urandom_range(0, 3) == 0));
      if (n % 10 == 0) idle_write(1'($urandom_range(0, 1)), 1'b1, $urandom());
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule